// File: doc/BRIEF.md
# Polarity-Selectable Interrupt Aggregator

The block collects eighteen external interrupt request lines and combines them into one active-high request for a parent interrupt controller. Each line passes through a two-flop synchronizer. A per-line polarity bit then decides whether the line is active high or active low. A pending bit is latched for each line, in either level or edge capture mode.

Software reaches the block through a small 32-bit register interface on a simple single-cycle read/write bus. There are five registers:

- a control word holding a global run bit and the capture-mode bit;
- a per-line enable mask;
- the pending status, which is read-only;
- a write-one-to-clear register;
- a per-line polarity register.

The parent request is raised while the controller is running and at least one enabled line has its pending bit set.

Top module: `irq_aggr_top`

## Requirements
- R1: The registers sit at byte addresses 0x00 (control), 0x04 (enable), 0x08 (status), 0x0C (clear) and 0x10 (polarity). Read data appears on `rdata_o` on the clock edge that samples the read request. Control, enable and polarity read back what was written, in their implemented bits.
- R2: Control bit 31 is the global run bit. When it is 0, `irq_o` is low and no status bit is newly set.
- R3: Control bit 30 selects the capture mode: 1 selects edge capture and 0 selects level capture.
- R4: Writing a word to the clear register clears every status bit (bits 17:0) whose data bit is 1. Data bits of 0 leave their status bits unchanged.
- R5: In edge mode, a rising edge of a line's active signal sets its status bit. The bit then stays set until it is cleared, and it is not set again while the line merely stays active.
- R6: In level mode, the status bit is set on every cycle the line is active. When a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Polarity bit i selects how line i is read: 1 makes the line active when high, and 0 makes it active when low.
- R8: `irq_o` is 1 exactly when the run bit is 1 and any bit of (enable AND status) is 1.
- R9: A change on an input line reaches the status register no later than the third rising clock edge after it.
- R10: The following read as 0:
  - control bits 29:0;
  - bits 31:18 of the enable, status and polarity registers;
  - the clear register and every unmapped address.

  Writes to the status register have no effect.
- R11: After reset, the control, enable, polarity and status registers are all 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_lines_i | input | 18 | Asynchronous interrupt request lines |
| irq_o | output | 1 | Combined active-high request to the parent |

## Verification
The bench holds a line active and clears its bit in both capture modes. A design that lets the clear win in level mode would lose a live request. A design that re-latches a held line in edge mode would raise an interrupt storm.

A line held active at its low polarity must latch. A design with the polarity sense inverted would latch the idle lines instead.

Dropping the run bit must lower `irq_o` and also block new captures; a design that gates only the output would leave stale pending bits behind. Writes of zero to the clear register, writes to the status register, and reads of unused bits or unmapped addresses all have to leave the visible state unchanged.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned CTL_RUN_BIT  = 31;
  localparam int unsigned CTL_EDGE_BIT = 30;
  localparam logic [7:0]  OFF_CTL      = 8'h00;
  localparam logic [7:0]  OFF_ENA      = 8'h04;
  localparam logic [7:0]  OFF_STS      = 8'h08;
  localparam logic [7:0]  OFF_CLR      = 8'h0C;
  localparam logic [7:0]  OFF_POL      = 8'h10;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
      end
    end
    assign sync_o[i] = s2_q;
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] pol_i,
  input  logic         run_i,
  input  logic         edge_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] active, prev_q, rise, set, sts_q;

  assign active = sync_i ^ ~pol_i;
  assign rise   = active & ~prev_q;
  assign set    = run_i ? (edge_i ? rise : active) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= active;
      sts_q  <= (sts_q & ~clr_i) | set;  // set beats clear
    end
  end

  assign sts_o = sts_q;

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0));

  assert_level_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !edge_i) |=> ((sts_q & $past(active)) == $past(active)));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(clr_i & ~set)) == '0));

  assert_halt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((sts_q & ~$past(sts_q)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_aggr_pkg::*;
#(
  parameter int unsigned N      = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      sts_i,
  output logic              run_o,
  output logic              edge_o,
  output logic [N-1:0]      ena_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - N;

  logic wr, rd, hit_ctl, hit_ena, hit_sts, hit_clr, hit_pol, unmapped;
  logic run_q, edge_q;
  logic [N-1:0] ena_q, pol_q;
  logic [DATA_W-1:0] rmux, rdata_q;
  logic unused_wdata;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign hit_ctl = addr_i == ADDR_W'(OFF_CTL);
  assign hit_ena = addr_i == ADDR_W'(OFF_ENA);
  assign hit_sts = addr_i == ADDR_W'(OFF_STS);
  assign hit_clr = addr_i == ADDR_W'(OFF_CLR);
  assign hit_pol = addr_i == ADDR_W'(OFF_POL);
  assign unmapped = ~(hit_ctl | hit_ena | hit_sts | hit_pol);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      edge_q <= 1'b0;
      ena_q  <= '0;
      pol_q  <= '0;
    end else if (wr) begin
      if (hit_ctl) begin
        run_q  <= wdata_i[CTL_RUN_BIT];
        edge_q <= wdata_i[CTL_EDGE_BIT];
      end
      if (hit_ena) ena_q <= wdata_i[N-1:0];
      if (hit_pol) pol_q <= wdata_i[N-1:0];
    end
  end

  assign clr_o = (wr && hit_clr) ? wdata_i[N-1:0] : '0;

  always_comb begin
    rmux = '0;
    if (hit_ctl) begin
      rmux[CTL_RUN_BIT]  = run_q;
      rmux[CTL_EDGE_BIT] = edge_q;
    end
    if (hit_ena) rmux = {{PAD_W{1'b0}}, ena_q};
    if (hit_sts) rmux = {{PAD_W{1'b0}}, sts_i};
    if (hit_pol) rmux = {{PAD_W{1'b0}}, pol_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rmux;
  end

  assign run_o   = run_q;
  assign edge_o  = edge_q;
  assign ena_o   = ena_q;
  assign pol_o   = pol_q;
  assign rdata_o = rdata_q;

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && unmapped) |=> (rdata_o == '0));

  assert_ena_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && hit_ena) |=> $stable(ena_q));
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
  import irq_aggr_pkg::*;
#(
  parameter int unsigned N      = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N-1:0]      irq_lines_i,
  output logic              irq_o
);
  logic run, edge_mode;
  logic [N-1:0] sync, ena, pol, clr, sts;

  irq_sync #(.N(N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(irq_lines_i), .sync_o(sync)
  );

  irq_capture #(.N(N)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .pol_i(pol),
    .run_i(run), .edge_i(edge_mode), .clr_i(clr), .sts_o(sts)
  );

  irq_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sts_i(sts), .run_o(run),
    .edge_o(edge_mode), .ena_o(ena), .pol_o(pol), .clr_o(clr),
    .rdata_o(rdata_o)
  );

  assign irq_o = run & |(ena & sts);

  assert_irq_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !irq_o);

  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ena & sts) != '0));
endmodule

// File: tb/sim_irq_aggr_top.sv
module sim_irq_aggr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [17:0] lines = '0;
  logic        irq;
  logic        rd_pend = 1'b0;
  logic        done = 1'b0;
  int          checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] A_CTL = 8'h00, A_ENA = 8'h04, A_STS = 8'h08,
                         A_CLR = 8'h0C, A_POL = 8'h10;

  always #4 clk = ~clk;

  irq_aggr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_lines_i(lines), .irq_o(irq)
  );

  always @(posedge clk) rd_pend <= req && !we;

  // monitor: pop expected read data one cycle after each read
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: act=%h exp=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: act=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk_irq(1'b0, "R11 irq after reset");
    rd(A_CTL, 32'h0, "R11 ctl reset");
    rd(A_ENA, 32'h0, "R11 ena reset");
    rd(A_POL, 32'h0, "R11 pol reset");
    rd(A_STS, 32'h0, "R11 sts reset (R2 no capture while stopped)");

    wr(A_POL, 32'h3FFFF);
    rd(A_POL, 32'h3FFFF, "R1 pol readback");
    wr(A_CTL, 32'h8000_0000);
    rd(A_CTL, 32'h8000_0000, "R1 ctl readback");
    wr(A_CLR, 32'h3FFFF);
    rd(A_STS, 32'h0, "R4 clear all");

    // level mode, line 3 high-active
    lines[3] = 1'b1;
    settle();
    rd(A_STS, 32'h8, "R9 R7 level capture line3");
    chk_irq(1'b0, "R8 masked line");
    wr(A_ENA, 32'h8);
    chk_irq(1'b1, "R8 enabled pending");
    wr(A_CLR, 32'h8);
    rd(A_STS, 32'h8, "R6 clear while active re-sets");
    lines[3] = 1'b0;
    settle();
    rd(A_STS, 32'h8, "R6 level bit held after line drops");
    wr(A_CLR, 32'h0);
    rd(A_STS, 32'h8, "R4 zero clear no effect");
    wr(A_STS, 32'h0);
    rd(A_STS, 32'h8, "R10 status write ignored");
    wr(A_CLR, 32'h8);
    rd(A_STS, 32'h0, "R4 clear line3");
    chk_irq(1'b0, "R8 cleared");

    // low polarity on line 5, line held low
    wr(A_POL, 32'h3FFDF);
    settle();
    rd(A_STS, 32'h20, "R7 active-low line5");
    wr(A_POL, 32'h3FFFF);
    settle();
    wr(A_CLR, 32'h3FFFF);
    rd(A_STS, 32'h0, "R7 restored polarity");

    // edge mode
    wr(A_CTL, 32'hC000_0000);
    rd(A_CTL, 32'hC000_0000, "R3 edge mode readback");
    lines[7] = 1'b1;
    settle();
    rd(A_STS, 32'h80, "R5 rising edge line7");
    wr(A_CLR, 32'h80);
    settle();
    rd(A_STS, 32'h0, "R5 R3 held line not recaptured");
    lines[7] = 1'b0;
    settle();
    rd(A_STS, 32'h0, "R5 falling edge no capture");
    lines[7] = 1'b1;
    settle();
    rd(A_STS, 32'h80, "R5 second rising edge");

    // global run bit
    wr(A_ENA, 32'h80);
    chk_irq(1'b1, "R8 edge pending enabled");
    wr(A_CTL, 32'h4000_0000);
    chk_irq(1'b0, "R2 stopped output low");
    rd(A_CTL, 32'h4000_0000, "R3 mode bit kept while stopped");
    wr(A_CLR, 32'h3FFFF);
    lines[9] = 1'b1;
    settle();
    rd(A_STS, 32'h0, "R2 no capture while stopped");

    // unused bits and unmapped addresses
    wr(A_ENA, 32'hFFFF_FFFF);
    rd(A_ENA, 32'h0003_FFFF, "R10 ena upper bits");
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, 32'hC000_0000, "R10 ctl unused bits");
    rd(A_CLR, 32'h0, "R10 clear reads zero");
    rd(8'h14, 32'h0, "R10 unmapped 0x14");
    rd(8'hFC, 32'h0, "R10 unmapped 0xFC");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule